// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block takes a snapshot of an external free-running count whenever a chosen transition shows up on an asynchronous input pin. The pin is first brought into the clock domain through a flop chain. The synchronized level is then compared with its value one cycle earlier, and the resulting rising or falling event is accepted or rejected according to a two-bit edge-mode control. An accepted event copies the count into a held capture register and marks it valid. One cycle later it raises a sticky interrupt request. The count source can count up or down; the unit only samples it.

The captured value is a held register, not a stream. It carries no valid/ready handshake and applies no back-pressure: the value stays until the next accepted event overwrites it. Software learns that a read was missed through the overrun flag. It acknowledges the interrupt with a one-cycle clear pulse, and that pulse also clears the overrun flag.

Top module: `pin_capture_unit`

## Requirements
- R1: While `rst_n` is low, `cap_value_o` is 0 and `cap_valid_o`, `irq_o` and `overrun_o` are all 0.
- R2: The pin goes through a two-flop synchronizer. After the pin changes, the change is detected in the cycle between the second and third rising clock edges. At the third edge the capture register loads the count present in that detection cycle.
- R3: With `edge_sel_i` = 2'b01, only a low-to-high pin transition captures. A high-to-low transition leaves the value and flags untouched.
- R4: With `edge_sel_i` = 2'b10, only a high-to-low pin transition captures. A low-to-high transition leaves the value and flags untouched.
- R5: With `edge_sel_i` = 2'b11, both transitions capture.
- R6: With `edge_sel_i` = 2'b00, pin activity causes no capture and changes no flag.
- R7: A capture loads `cap_value_o` with the `cnt_i` value of the detection cycle and sets `cap_valid_o`. `cap_valid_o` then stays high until reset. Without a capture, `cap_value_o` holds.
- R8: `irq_o` rises exactly one cycle after the capture register is updated, never in the same cycle.
- R9: `irq_o` stays high until a cycle with `irq_clr_i` high. That cycle clears both `irq_o` and `overrun_o` at the next edge.
- R10: A capture that happens while `irq_o` is high, or while an interrupt is still pending from the previous cycle, sets `overrun_o`.
- R11: When an interrupt or overrun is being set in the same cycle that `irq_clr_i` is high, the set wins and the flag ends high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W (16) | Free-running count to be sampled |
| pin_async_i | input | 1 | Asynchronous capture pin |
| edge_sel_i | input | 2 | Edge mode: 00 off, 01 rising, 10 falling, 11 both |
| irq_clr_i | input | 1 | Clears interrupt and overrun flags |
| cap_value_o | output | CNT_W (16) | Last captured count |
| cap_valid_o | output | 1 | At least one capture since reset |
| irq_o | output | 1 | Sticky interrupt request |
| overrun_o | output | 1 | A capture arrived before the previous one was acknowledged |

## Verification
A software clear and a fresh interrupt set can land in the same cycle. So can a clear and a new overrun event. A directed case places the clear pulse in exactly the cycle where the pending capture promotes into `irq_o`, and the flag must end high. Random clear pulses laid over random pin toggles recreate both collisions many times more. Every cycle is judged against a cycle model in the bench that applies set-over-clear priority.

// File: rtl/pin_capture_pkg.sv
package pin_capture_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_pair_t;

  function automatic logic mode_accepts(edge_mode_e mode, edge_pair_t ev);
    logic ok;
    unique case (mode)
      EDGE_OFF:  ok = 1'b0;
      EDGE_RISE: ok = ev.rise;
      EDGE_FALL: ok = ev.fall;
      EDGE_ANY:  ok = ev.rise | ev.fall;
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/pin_synchronizer.sv
module pin_synchronizer #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain_q[LAST];
endmodule

// File: rtl/edge_classifier.sv
module edge_classifier
  import pin_capture_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level,
  input  edge_mode_e mode,
  output logic       hit
);
  logic       last_q;
  edge_pair_t ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= level;
  end

  always_comb begin
    ev.rise = level & ~last_q;
    ev.fall = ~level & last_q;
    hit     = mode_accepts(mode, ev);
  end
endmodule

// File: rtl/capture_store.sv
module capture_store #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] value,
  output logic             valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      valid <= 1'b0;
    end else if (hit) begin
      value <= cnt;
      valid <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_flags.sv
module irq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  output logic irq,
  output logic overrun
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      irq     <= 1'b0;
      overrun <= 1'b0;
    end else begin
      pend_q <= hit;
      if (pend_q)   irq <= 1'b1;
      else if (clr) irq <= 1'b0;
      if (hit && (irq || pend_q)) overrun <= 1'b1;
      else if (clr)               overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/pin_capture_unit.sv
module pin_capture_unit
  import pin_capture_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             pin_async_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] cap_value_o,
  output logic             cap_valid_o,
  output logic             irq_o,
  output logic             overrun_o
);
  logic pin_sync;
  logic edge_hit;

  pin_synchronizer #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_async_i),
    .q_sync  (pin_sync)
  );

  edge_classifier u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (pin_sync),
    .mode  (edge_mode_e'(edge_sel_i)),
    .hit   (edge_hit)
  );

  capture_store #(.CNT_W(CNT_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (edge_hit),
    .cnt   (cnt_i),
    .value (cap_value_o),
    .valid (cap_valid_o)
  );

  irq_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (edge_hit),
    .clr     (irq_clr_i),
    .irq     (irq_o),
    .overrun (overrun_o)
  );
endmodule

// File: rtl/pin_capture_checker.sv
module pin_capture_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             edge_hit,
  input logic [CNT_W-1:0] cnt_i,
  input logic [1:0]       edge_sel_i,
  input logic             irq_clr_i,
  input logic [CNT_W-1:0] cap_value_o,
  input logic             cap_valid_o,
  input logic             irq_o,
  input logic             overrun_o
);
  // R7
  value_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> (cap_value_o == $past(cnt_i)));
  // R7
  value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_hit |=> $stable(cap_value_o));
  // R7
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid_o |=> cap_valid_o);
  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel_i == 2'b00) |=> ($stable(cap_value_o) && $stable(cap_valid_o)));
  // R8
  irq_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(edge_hit, 2));
  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o);
  // R10
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && irq_o) |=> overrun_o);
  // R10
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_o) |-> $past(edge_hit));
endmodule

bind pin_capture_unit pin_capture_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .edge_hit    (edge_hit),
  .cnt_i       (cnt_i),
  .edge_sel_i  (edge_sel_i),
  .irq_clr_i   (irq_clr_i),
  .cap_value_o (cap_value_o),
  .cap_valid_o (cap_valid_o),
  .irq_o       (irq_o),
  .overrun_o   (overrun_o)
);

// File: tb/pin_capture_unit_bench.sv
module pin_capture_unit_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cnt_q = '0;
  logic         pin_q = 1'b0;
  logic [1:0]   sel_q = 2'b00;
  logic         clr_q = 1'b0;
  logic         dir_up = 1'b1;

  logic [W-1:0] cap_value_o;
  logic         cap_valid_o, irq_o, overrun_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic         m_s1 = 0, m_s2 = 0, m_prev = 0, m_pend = 0;
  logic         m_irq = 0, m_ovr = 0, m_valid = 0;
  logic [W-1:0] m_val = '0;

  always #4 clk = ~clk;

  pin_capture_unit u_pin_capture_unit (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_q), .pin_async_i(pin_q),
    .edge_sel_i(sel_q), .irq_clr_i(clr_q), .cap_value_o(cap_value_o),
    .cap_valid_o(cap_valid_o), .irq_o(irq_o), .overrun_o(overrun_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_advance();
    logic rise, fall, det;
    if (!rst_n) begin
      {m_s1, m_s2, m_prev, m_pend, m_irq, m_ovr, m_valid} = '0;
      m_val = '0;
    end else begin
      rise = m_s2 & ~m_prev;
      fall = ~m_s2 & m_prev;
      det  = (sel_q[0] & rise) | (sel_q[1] & fall);
      if (det && (m_irq || m_pend)) m_ovr = 1'b1;
      else if (clr_q)               m_ovr = 1'b0;
      if (m_pend)     m_irq = 1'b1;
      else if (clr_q) m_irq = 1'b0;
      m_pend = det;
      if (det) begin m_val = cnt_q; m_valid = 1'b1; end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_q;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_advance();
    @(negedge clk);
    check(cap_value_o == m_val, "R7 value", 32'(cap_value_o), 32'(m_val));
    check(cap_valid_o == m_valid, "R7 valid", 32'(cap_valid_o), 32'(m_valid));
    check(irq_o == m_irq, "R9 irq", 32'(irq_o), 32'(m_irq));
    check(overrun_o == m_ovr, "R10 overrun", 32'(overrun_o), 32'(m_ovr));
    cnt_q = dir_up ? cnt_q + 1'b1 : cnt_q - 1'b1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    logic [W-1:0] c, keep;
    void'($urandom(32'd20240611));
    ticks(3);
    check(cap_value_o == 0 && !cap_valid_o && !irq_o && !overrun_o, "R1 reset state",
          {cap_value_o, 13'd0, cap_valid_o, irq_o, overrun_o}, 32'd0);
    rst_n = 1'b1;
    ticks(4);

    // R2 / R3 / R8: rising capture timing
    sel_q = 2'b01;
    ticks(2);
    c = cnt_q; pin_q = 1'b1;
    ticks(3);
    check(cap_value_o == 16'(c + 16'd2), "R2 capture on third edge", 32'(cap_value_o), 32'(16'(c + 16'd2)));
    check(irq_o == 1'b0, "R8 irq not with latch", 32'(irq_o), 32'd0);
    tick();
    check(irq_o == 1'b1, "R8 irq one cycle later", 32'(irq_o), 32'd1);

    // R3: falling edge ignored in rising mode
    keep = cap_value_o; pin_q = 1'b0;
    ticks(5);
    check(cap_value_o == keep, "R3 fall ignored", 32'(cap_value_o), 32'(keep));
    check(overrun_o == 1'b0, "R3 no overrun on ignored edge", 32'(overrun_o), 32'd0);
    check(irq_o == 1'b1, "R9 irq sticky", 32'(irq_o), 32'd1);
    clr_q = 1'b1; tick(); clr_q = 1'b0;
    check(irq_o == 1'b0, "R9 clear", 32'(irq_o), 32'd0);

    // R4: falling mode
    sel_q = 2'b10; ticks(2);
    keep = cap_value_o; pin_q = 1'b1;
    ticks(5);
    check(cap_value_o == keep && !irq_o, "R4 rise ignored", 32'(cap_value_o), 32'(keep));
    c = cnt_q; pin_q = 1'b0;
    ticks(3);
    check(cap_value_o == 16'(c + 16'd2), "R4 fall capture", 32'(cap_value_o), 32'(16'(c + 16'd2)));
    tick();
    clr_q = 1'b1; tick(); clr_q = 1'b0;

    // R5 / R10: both edges, second capture overruns
    sel_q = 2'b11; ticks(2);
    c = cnt_q; pin_q = 1'b1;
    ticks(3);
    check(cap_value_o == 16'(c + 16'd2), "R5 rise capture", 32'(cap_value_o), 32'(16'(c + 16'd2)));
    c = cnt_q; pin_q = 1'b0;
    ticks(3);
    check(cap_value_o == 16'(c + 16'd2), "R5 fall capture", 32'(cap_value_o), 32'(16'(c + 16'd2)));
    tick();
    check(overrun_o == 1'b1, "R10 overrun", 32'(overrun_o), 32'd1);
    clr_q = 1'b1; tick(); clr_q = 1'b0;
    check(!irq_o && !overrun_o, "R9 clear both", {30'd0, irq_o, overrun_o}, 32'd0);

    // R6: disabled
    sel_q = 2'b00; keep = cap_value_o;
    for (int k = 0; k < 4; k++) begin pin_q = ~pin_q; ticks(4); end
    check(cap_value_o == keep && cap_valid_o && !irq_o && !overrun_o, "R6 disabled quiet",
          {cap_value_o, 13'd0, cap_valid_o, irq_o, overrun_o}, {keep, 13'd0, 3'b100});

    // R11: clear collides with pending set
    sel_q = 2'b01; ticks(2);
    pin_q = 1'b1;
    ticks(3);
    clr_q = 1'b1; tick(); clr_q = 1'b0;
    check(irq_o == 1'b1, "R11 set beats clear", 32'(irq_o), 32'd1);
    clr_q = 1'b1; tick(); clr_q = 1'b0;

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(5) == 0)   pin_q = ~pin_q;
      if ($urandom_range(49) == 0)  sel_q = 2'($urandom_range(3));
      if ($urandom_range(199) == 0) dir_up = ~dir_up;
      clr_q = ($urandom_range(15) == 0);
      tick();
    end
    clr_q = 1'b0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule